// File: doc/BRIEF.md
# Prioritized Interrupt Arbitration Unit

This block receives a bank of interrupt request lines. Each line carries its own 4-bit priority, from 0 (lowest) to 15 (highest). Every cycle it works out which asserted line holds the highest priority. When several lines share that priority, it picks the one with the smallest index. The index of the chosen line becomes its 9-bit vector.

The winning priority is compared against a current-priority value supplied by the processor side. A registered interrupt request to the processor is raised only while the winner is strictly above that value. The request therefore reacts both when a more urgent line appears and when the current priority is lowered.

When the processor acknowledges a raised request, the block captures the winning vector and priority into holding registers. The processor reads the vector from there and loads the priority as its new current priority. Later changes on the request lines do not disturb the captured values.

A small two-state machine tracks the processor request:

- `ST_QUIET` means no request is raised.
- `ST_RAISED` means the request is raised.
- The transition *preempt* (`ST_QUIET` to `ST_RAISED`) is taken when the winner exceeds the current priority.
- The transition *settle* (`ST_RAISED` to `ST_QUIET`) is taken when it no longer does.
- While the machine is in `ST_RAISED`, the event *handover* (acknowledge) latches the vector and priority.

Top module: `irq_arb_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `cpu_irq_o` is 0, `ack_vec_o` is 0 and `ack_prio_o` is 0.
- R2: On a handover, `ack_prio_o` becomes the largest priority among the asserted request lines; priority of source i is `prio_i[4*i+3:4*i]`.
- R3: When several asserted lines share the largest priority, the captured vector is the smallest index among them.
- R4: The vector is the source index i, zero-extended to 9 bits.
- R5: `cpu_irq_o` is 1 in the cycle after a clock edge exactly when some asserted line had a priority strictly greater than `cur_prio_i` at that edge; equal priority gives 0.
- R6: Lowering `cur_prio_i` below a pending priority, with the requests unchanged, raises `cpu_irq_o` one cycle later.
- R7: If every asserted line has priority 0, `cpu_irq_o` stays 0 for any `cur_prio_i`.
- R8: `ack_i` sampled while `cpu_irq_o` is 0 leaves `ack_vec_o` and `ack_prio_o` unchanged.
- R9: After a handover, `ack_vec_o` and `ack_prio_o` hold their values while the request lines and priorities change, until the next handover.
- R10: A deasserted request line never wins, whatever priority is programmed for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NSRC | Interrupt request lines, bit i is source i |
| prio_i | input | 4*NSRC | Packed priorities, 4 bits per source, source 0 in the low nibble |
| cur_prio_i | input | 4 | Current priority of the processor |
| ack_i | input | 1 | Acknowledge from the processor |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |
| ack_vec_o | output | 9 | Vector captured at the last handover |
| ack_prio_o | output | 4 | Priority captured at the last handover, to be loaded as the new current priority |

## Verification
The unit is driven with an eight-source configuration.

- An exhaustive sweep of all 256 request masks over two fixed priority maps separates max-priority selection from lowest-index tie breaking. One map has distinct levels and one has every source tied, so a wrong priority rule and a wrong tie rule produce different vectors.
- Pseudo-random masks and priorities, run at every current-priority value from 0 to 15, probe the strict-greater compare at its equality boundary.
- Directed sequences cover lowering the current priority under a fixed pending set, and sources held at priority 0 or deasserted with priority 15.
- Further directed sequences cover an acknowledge arriving with no raised request, and request changes after a handover. These tell apart a compare that only reacts to new requests, and capture registers that follow the live winner.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 9;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // Handover state machine: QUIET = no request to the processor,
    // RAISED = request to the processor is up.
    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } hand_state_e;

    // Result of one arbitration round.
    typedef struct packed {
        logic  found;
        prio_t prio;
        vec_t  vec;
    } win_t;

endpackage

// File: rtl/irq_prio_max.sv
// Finds the largest priority among asserted request lines.
module irq_prio_max
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0]        req_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    output prio_t                  max_prio_o,
    output logic                   any_o
);

    logic [NSRC-1:0][PRIO_W-1:0] masked;

    // Deasserted lines contribute nothing, whatever their programmed level.
    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_mask
            assign masked[g] = req_i[g] ? prio_i[g*PRIO_W +: PRIO_W] : '0;
        end
    endgenerate

    always_comb begin
        max_prio_o = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (masked[i] > max_prio_o) begin
                max_prio_o = masked[i];
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/irq_low_select.sv
// Among lines asserted at the winning priority, picks the lowest index
// and encodes it as the vector.
module irq_low_select
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic [NSRC-1:0]        req_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  prio_t                  max_prio_i,
    output vec_t                   vec_o,
    output logic                   found_o
);

    logic [NSRC-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < NSRC; g++) begin : g_hit
            assign hit[g] = req_i[g] && (prio_i[g*PRIO_W +: PRIO_W] == max_prio_i);
        end
    endgenerate

    // Walk from the top index down so the lowest matching index wins.
    always_comb begin
        vec_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (hit[i]) begin
                vec_o = vec_t'(i);
            end
        end
    end

    assign found_o = |hit;

endmodule

// File: rtl/irq_handover_fsm.sv
// Tracks the processor request and captures the winner on acknowledge.
module irq_handover_fsm
    import irq_arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  preempt_i,
    input  logic  ack_i,
    input  win_t  win_i,
    output logic  cpu_irq_o,
    output vec_t  ack_vec_o,
    output prio_t ack_prio_o
);

    hand_state_e state_q, state_d;
    logic        handover;

    // Next state: preempt (QUIET->RAISED), settle (RAISED->QUIET).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (preempt_i)  state_d = ST_RAISED;
            ST_RAISED: if (!preempt_i) state_d = ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // Handover only counts while the request is visibly raised.
    always_comb begin
        handover = 1'b0;
        unique case (state_q)
            ST_QUIET:  handover = 1'b0;
            ST_RAISED: handover = ack_i;
            default:   handover = 1'b0;
        endcase
    end

    // Output capture registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_vec_o  <= '0;
            ack_prio_o <= '0;
        end else if (handover) begin
            ack_vec_o  <= win_i.vec;
            ack_prio_o <= win_i.prio;
        end
    end

    assign cpu_irq_o = (state_q == ST_RAISED);

endmodule

// File: rtl/irq_arb_top.sv
module irq_arb_top
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 64
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NSRC-1:0]        req_i,
    input  logic [NSRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]      cur_prio_i,
    input  logic                   ack_i,
    output logic                   cpu_irq_o,
    output logic [VEC_W-1:0]       ack_vec_o,
    output logic [PRIO_W-1:0]      ack_prio_o
);

    localparam int MAX_SRC = 1 << VEC_W;

    prio_t max_prio;
    logic  any_req;
    vec_t  sel_vec;
    logic  sel_found;
    win_t  win;
    logic  preempt;

    generate
        if (NSRC > MAX_SRC || NSRC < 1) begin : g_bad_cfg
            initial $error("irq_arb_top: NSRC out of range for vector width");
        end
    endgenerate

    irq_prio_max #(.NSRC(NSRC)) u_max (
        .req_i      (req_i),
        .prio_i     (prio_i),
        .max_prio_o (max_prio),
        .any_o      (any_req)
    );

    irq_low_select #(.NSRC(NSRC)) u_sel (
        .req_i      (req_i),
        .prio_i     (prio_i),
        .max_prio_i (max_prio),
        .vec_o      (sel_vec),
        .found_o    (sel_found)
    );

    assign win.found = any_req && sel_found;
    assign win.prio  = max_prio;
    assign win.vec   = sel_vec;

    // Strict compare: level 0 can never exceed any current priority.
    assign preempt = win.found && (win.prio > cur_prio_i);

    irq_handover_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .preempt_i  (preempt),
        .ack_i      (ack_i),
        .win_i      (win),
        .cpu_irq_o  (cpu_irq_o),
        .ack_vec_o  (ack_vec_o),
        .ack_prio_o (ack_prio_o)
    );

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NSRC-1:0]        req_i,
    input logic [NSRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]      cur_prio_i,
    input logic                   ack_i,
    input logic                   cpu_irq_o,
    input logic [VEC_W-1:0]       ack_vec_o,
    input logic [PRIO_W-1:0]      ack_prio_o
);

    logic live_nonzero;
    always_comb begin
        live_nonzero = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (req_i[i] && (prio_i[i*PRIO_W +: PRIO_W] != '0)) begin
                live_nonzero = 1'b1;
            end
        end
    end

    // R7
    zero_prio_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live_nonzero |=> !cpu_irq_o);

    // R5
    top_level_never_beaten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_prio_i == '1) |=> !cpu_irq_o);

    // R2
    handover_above_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_irq_o && ack_i) |=> (ack_prio_o > $past(cur_prio_i)));

    // R8
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_irq_o && ack_i) |=> ($stable(ack_vec_o) && $stable(ack_prio_o)));

    // R4
    vector_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vec_o < VEC_W'(NSRC));

endmodule

bind irq_arb_top irq_arb_chk #(.NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .prio_i     (prio_i),
    .cur_prio_i (cur_prio_i),
    .ack_i      (ack_i),
    .cpu_irq_o  (cpu_irq_o),
    .ack_vec_o  (ack_vec_o),
    .ack_prio_o (ack_prio_o)
);

// File: tb/sim_irq_arb_top.sv
`timescale 1ns/1ps
module sim_irq_arb_top;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N*4-1:0] prio = '0;
    logic [3:0]   cur = '0;
    logic         ack = 1'b0;
    logic         irq;
    logic [8:0]   avec;
    logic [3:0]   aprio;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    irq_arb_top #(.NSRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .req_i(req), .prio_i(prio),
        .cur_prio_i(cur), .ack_i(ack), .cpu_irq_o(irq),
        .ack_vec_o(avec), .ack_prio_o(aprio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [N-1:0] r, input logic [N*4-1:0] p,
                                  output int mp, output int mv, output bit any);
        mp = 0; mv = 0; any = 0;
        for (int i = 0; i < N; i++) begin
            if (r[i]) begin
                if (!any || int'(p[i*4 +: 4]) > mp) begin
                    mp = int'(p[i*4 +: 4]);
                    mv = i;
                end
                any = 1;
            end
        end
    endfunction

    task automatic next_rand();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    // Apply inputs, check the request, and hand over when raised.
    task automatic apply(input logic [N-1:0] r, input logic [N*4-1:0] p,
                         input logic [3:0] c, input string tag);
        int mp, mv; bit any; bit exp_irq;
        @(negedge clk);
        req = r; prio = p; cur = c;
        @(negedge clk);
        model(r, p, mp, mv, any);
        exp_irq = any && (mp > int'(c));
        chk({tag, " R5 irq"}, int'(irq), int'(exp_irq));
        if (exp_irq) begin
            ack = 1'b1;
            @(negedge clk);
            ack = 1'b0;
            chk({tag, " R2 prio"}, int'(aprio), mp);
            chk({tag, " R3 R4 vec"}, int'(avec), mv);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [N*4-1:0] pa, pb;
        logic [8:0] hv; logic [3:0] hp;
        repeat (2) @(negedge clk);
        // R1
        chk("R1 irq in reset", int'(irq), 0);
        chk("R1 vec in reset", int'(avec), 0);
        chk("R1 prio in reset", int'(aprio), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", int'(irq), 0);
        chk("R1 vec after reset", int'(avec), 0);

        // Exhaustive masks: distinct map and fully tied map.
        pa = {4'd3, 4'd7, 4'd1, 4'd7, 4'd0, 4'd5, 4'd7, 4'd2};
        pb = {N{4'd9}};
        for (int m = 0; m < 256; m++) apply(N'(m), pa, 4'd0, "sweepA");
        for (int m = 0; m < 256; m++) apply(N'(m), pb, 4'd3, "sweepB R3");

        // Random patterns at every current priority, including equality.
        for (int c = 0; c < 16; c++) begin
            for (int k = 0; k < 120; k++) begin
                next_rand(); pa[31:0] = lfsr;
                next_rand();
                apply(lfsr[N-1:0], pa, 4'(c), "rand");
            end
        end

        // R5 equality boundary
        apply(8'b0001_0000, {4'd0, 4'd0, 4'd0, 4'd6, 4'd0, 4'd0, 4'd0, 4'd0}, 4'd6, "R5 equal");
        chk("R5 equal stays low", int'(irq), 0);

        // R6 lowering the current priority
        @(negedge clk);
        cur = 4'd2;
        @(negedge clk);
        chk("R6 lowered cur raises irq", int'(irq), 1);

        // R7 priority 0 sources only
        apply(8'hFF, '0, 4'd0, "R7");
        chk("R7 zero prio no irq", int'(irq), 0);

        // R10 deasserted line with priority 15 never wins
        apply(8'b0000_0100, {4'd15, 4'd15, 4'd15, 4'd15, 4'd15, 4'd4, 4'd15, 4'd15}, 4'd0, "R10");
        chk("R10 vec", int'(avec), 2);
        chk("R10 prio", int'(aprio), 4);

        // R8 acknowledge without a raised request
        hv = avec; hp = aprio;
        @(negedge clk);
        req = 8'b1000_0000; prio = {4'd12, 28'd0}; cur = 4'd15;
        @(negedge clk);
        chk("R8 irq low", int'(irq), 0);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        chk("R8 vec unchanged", int'(avec), int'(hv));
        chk("R8 prio unchanged", int'(aprio), int'(hp));

        // R9 captured values hold while requests change
        apply(8'b0010_0000, {4'd0, 4'd0, 4'd11, 20'd0}, 4'd1, "R9 setup");
        @(negedge clk);
        req = 8'b0000_0011; prio = {24'd0, 4'd14, 4'd13}; cur = 4'd0;
        repeat (3) @(negedge clk);
        chk("R9 irq raised", int'(irq), 1);
        chk("R9 vec held", int'(avec), 5);
        chk("R9 prio held", int'(aprio), 11);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule